// File: doc/BRIEF.md
# Memory-Mapped Character I/O Port

This peripheral sits on a simple register bus and gives software two independent character channels. The receive channel takes bytes from an external stream, where each byte arrives with a one-cycle strobe, and keeps one of them in a holding register. A status flag tells software that a character is waiting. Software reads the character and then writes zero to the status word, which frees the holding register for the next byte. A byte that arrives while the holding register is still full is dropped, and a sticky overrun flag records the loss.

The transmit channel holds one character written by software. Writing one to the transmit status word starts delivery to an external sink over a valid/ready handshake. The status reads busy until the sink accepts the byte. Hardware then clears busy and sets a done flag.

Each channel drives a level interrupt line, and a control word masks each line. Software can therefore poll the status words, or it can wait for the interrupts.

Top module: `charport_mmio`

## Requirements
- R1: After reset, every status word reads 0, the control word reads 0, `out_valid` is low and both interrupt lines are low.
- R2: A strobe while the receive holding register is empty captures `in_byte`. After that, receive status bit 0 reads 1 and the receive data word (offset 0x0) returns the byte.
- R3: A strobe while the receive register is full drops the byte and leaves the held data unchanged. It also sets receive status bit 1 (overrun), unless the same cycle carries an acknowledge.
- R4: Writing receive status (offset 0x1) with bit 0 = 0 clears the full flag. Any write to receive status clears the overrun flag. Writing bit 0 = 1 does not change the full flag.
- R5: When an acknowledge write and a strobe fall in the same cycle, the new byte is captured, the full flag stays 1 and overrun is not set.
- R6: Writing 1 to transmit status bit 0 (offset 0x11) while the channel is idle raises `out_valid` in the next cycle. `out_byte` then equals the transmit data word (offset 0x10), and transmit status bit 0 reads 1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold. After the cycle in which both are high, `out_valid` drops, transmit status bit 0 reads 0 and bit 1 (done) reads 1.
- R8: Writing 1 to transmit status while busy, or writing 0 to it at any time, has no effect on the transfer in progress or on the status.
- R9: `irq_in` equals receive full AND control bit 0. `irq_out` equals done AND control bit 1. Done stays set until the next accepted start clears it.
- R10: `bus_ready` is high in every cycle in which `bus_sel` is high. Reads return data in that same cycle. Reads of unmapped offsets return 0.
- R11: The control word at offset 0x20 reads back the two enable bits last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset from the block base |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| bus_ready | output | 1 | Access completes this cycle |
| in_strobe | input | 1 | One-cycle marker of an incoming byte |
| in_byte | input | CHAR_W | Incoming byte |
| out_valid | output | 1 | Transmit byte is offered |
| out_ready | input | 1 | Sink accepts the offered byte |
| out_byte | output | CHAR_W | Transmit byte |
| irq_in | output | 1 | Receive interrupt, level |
| irq_out | output | 1 | Transmit-done interrupt, level |

## Verification
The bench sends a second byte into a full receive register. A design that overwrote the held byte, or that left overrun clear, shows up as a wrong data or status read. The bench also places an acknowledge and a strobe in the same cycle, so a design that lets the clear win and loses the byte is caught. On the transmit side, the bench holds `out_ready` low and issues start writes while the channel is busy. A design that reloaded the byte, or that treated a written zero as a cancel, changes `out_byte` or the status. A queue-based scoreboard then runs a burst under a ready pattern that keeps changing, and it catches lost, repeated or reordered characters.

// File: rtl/chario_pkg.sv
package chario_pkg;
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RX_DATA,
      SEL_RX_STAT,
      SEL_TX_DATA,
      SEL_TX_STAT,
      SEL_CTRL
   } reg_sel_t;

   localparam int FLAG_LO_BIT = 0;
   localparam int FLAG_HI_BIT = 1;
endpackage

// File: rtl/chario_decode.sv
module chario_decode
   import chario_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int RX_DATA_OFS = 'h00,
   parameter int RX_STAT_OFS = 'h01,
   parameter int TX_DATA_OFS = 'h10,
   parameter int TX_STAT_OFS = 'h11,
   parameter int CTRL_OFS    = 'h20
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_t          sel
);
   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(RX_DATA_OFS))      sel = SEL_RX_DATA;
      else if (addr == ADDR_W'(RX_STAT_OFS)) sel = SEL_RX_STAT;
      else if (addr == ADDR_W'(TX_DATA_OFS)) sel = SEL_TX_DATA;
      else if (addr == ADDR_W'(TX_STAT_OFS)) sel = SEL_TX_STAT;
      else if (addr == ADDR_W'(CTRL_OFS))    sel = SEL_CTRL;
   end
endmodule

// File: rtl/chario_rx.sv
module chario_rx #(
   parameter int CHAR_W = 8,
   parameter bit OVR_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_strobe,
   input  logic [CHAR_W-1:0] in_byte,
   input  logic              stat_wr,
   input  logic              stat_bit0,
   output logic              full,
   output logic              ovr,
   output logic [CHAR_W-1:0] held
);
   logic ack;
   logic take;

   assign ack  = stat_wr && !stat_bit0;
   assign take = in_strobe && (!full || ack);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= '0;
      end else if (take) begin
         full <= 1'b1;
         held <= in_byte;
      end else if (ack) begin
         full <= 1'b0;
      end
   end

   generate
      if (OVR_EN) begin : g_ovr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         ovr <= 1'b0;
            else if (in_strobe && full && !ack) ovr <= 1'b1;
            else if (stat_wr)                   ovr <= 1'b0;
         end
      end else begin : g_no_ovr
         assign ovr = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/chario_tx.sv
module chario_tx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [CHAR_W-1:0] wdata,
   input  logic              stat_wr,
   input  logic              stat_bit0,
   input  logic              out_ready,
   output logic              busy,
   output logic              done,
   output logic [CHAR_W-1:0] hold,
   output logic [CHAR_W-1:0] cur
);
   logic start;

   assign start = stat_wr && stat_bit0 && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hold <= '0;
      else if (data_wr) hold <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         done <= 1'b0;
         cur  <= '0;
      end else if (start) begin
         busy <= 1'b1;
         done <= 1'b0;
         cur  <= hold;
      end else if (busy && out_ready) begin
         busy <= 1'b0;
         done <= 1'b1;
      end
   end
endmodule

// File: rtl/charport_mmio.sv
module charport_mmio
   import chario_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int CHAR_W      = 8,
   parameter bit OVR_EN      = 1'b1,
   parameter int RX_DATA_OFS = 'h00,
   parameter int RX_STAT_OFS = 'h01,
   parameter int TX_DATA_OFS = 'h10,
   parameter int TX_STAT_OFS = 'h11,
   parameter int CTRL_OFS    = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   input  logic              in_strobe,
   input  logic [CHAR_W-1:0] in_byte,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [CHAR_W-1:0] out_byte,
   output logic              irq_in,
   output logic              irq_out
);
   localparam int OFS_LIMIT = 1 << ADDR_W;

   generate
      if (CHAR_W > DATA_W || DATA_W < 2)
         $error("charport_mmio: CHAR_W must fit DATA_W, DATA_W >= 2");
      if (RX_DATA_OFS >= OFS_LIMIT || RX_STAT_OFS >= OFS_LIMIT || TX_DATA_OFS >= OFS_LIMIT ||
          TX_STAT_OFS >= OFS_LIMIT || CTRL_OFS >= OFS_LIMIT)
         $error("charport_mmio: offset exceeds ADDR_W");
      if (RX_DATA_OFS == RX_STAT_OFS || TX_DATA_OFS == TX_STAT_OFS ||
          RX_STAT_OFS == TX_STAT_OFS || CTRL_OFS == RX_STAT_OFS || CTRL_OFS == TX_STAT_OFS)
         $error("charport_mmio: register offsets collide");
   endgenerate

   reg_sel_t          rsel;
   logic              wr_en;
   logic              rx_full, rx_ovr, tx_busy, tx_done, in_ack;
   logic [CHAR_W-1:0] rx_held, tx_hold;
   logic [1:0]        ctrl_en;

   assign wr_en     = bus_sel && bus_wr;
   assign bus_ready = bus_sel;
   assign in_ack    = wr_en && (rsel == SEL_RX_STAT) && !bus_wdata[0];

   chario_decode #(
      .ADDR_W(ADDR_W), .RX_DATA_OFS(RX_DATA_OFS), .RX_STAT_OFS(RX_STAT_OFS),
      .TX_DATA_OFS(TX_DATA_OFS), .TX_STAT_OFS(TX_STAT_OFS), .CTRL_OFS(CTRL_OFS)
   ) u_dec (
      .addr(bus_addr),
      .sel (rsel)
   );

   chario_rx #(.CHAR_W(CHAR_W), .OVR_EN(OVR_EN)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_strobe(in_strobe),
      .in_byte  (in_byte),
      .stat_wr  (wr_en && (rsel == SEL_RX_STAT)),
      .stat_bit0(bus_wdata[0]),
      .full     (rx_full),
      .ovr      (rx_ovr),
      .held     (rx_held)
   );

   chario_tx #(.CHAR_W(CHAR_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (wr_en && (rsel == SEL_TX_DATA)),
      .wdata    (bus_wdata[CHAR_W-1:0]),
      .stat_wr  (wr_en && (rsel == SEL_TX_STAT)),
      .stat_bit0(bus_wdata[0]),
      .out_ready(out_ready),
      .busy     (tx_busy),
      .done     (tx_done),
      .hold     (tx_hold),
      .cur      (out_byte)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_en <= 2'b00;
      else if (wr_en && rsel == SEL_CTRL)  ctrl_en <= bus_wdata[1:0];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         case (rsel)
            SEL_RX_DATA: bus_rdata[CHAR_W-1:0] = rx_held;
            SEL_RX_STAT: begin
               bus_rdata[FLAG_LO_BIT] = rx_full;
               bus_rdata[FLAG_HI_BIT] = rx_ovr;
            end
            SEL_TX_DATA: bus_rdata[CHAR_W-1:0] = tx_hold;
            SEL_TX_STAT: begin
               bus_rdata[FLAG_LO_BIT] = tx_busy;
               bus_rdata[FLAG_HI_BIT] = tx_done;
            end
            SEL_CTRL:    bus_rdata[1:0] = ctrl_en;
            default:     bus_rdata = '0;
         endcase
      end
   end

   assign out_valid = tx_busy;
   assign irq_in    = rx_full && ctrl_en[0];
   assign irq_out   = tx_done && ctrl_en[1];
endmodule

// File: rtl/chario_checks.sv
module chario_checks #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_strobe,
   input logic              in_ack,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic              tx_done,
   input logic              out_valid,
   input logic              out_ready,
   input logic [CHAR_W-1:0] out_byte,
   input logic              irq_in,
   input logic              irq_out
);
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      in_strobe && !rx_full |=> rx_full);

   a_r3_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      in_strobe && rx_full && !in_ack |=> rx_ovr);

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_byte));

   a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid && tx_done);

   a_r9_irq_in: assert property (@(posedge clk) disable iff (!rst_n)
      irq_in |-> rx_full);

   a_r9_irq_out: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> !out_valid);
endmodule

bind charport_mmio chario_checks #(.CHAR_W(CHAR_W)) u_checks (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_strobe(in_strobe),
   .in_ack   (in_ack),
   .rx_full  (rx_full),
   .rx_ovr   (rx_ovr),
   .tx_done  (tx_done),
   .out_valid(out_valid),
   .out_ready(out_ready),
   .out_byte (out_byte),
   .irq_in   (irq_in),
   .irq_out  (irq_out)
);

// File: tb/charport_mmio_test.sv
`timescale 1ns/1ps
module charport_mmio_test;
   localparam int AW = 8, DW = 32, CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_ready;
   logic          in_strobe = 1'b0;
   logic [CW-1:0] in_byte = '0;
   logic          out_valid, out_ready = 1'b0;
   logic [CW-1:0] out_byte;
   logic          irq_in, irq_out;

   int checks = 0, errors = 0, hs_cnt = 0, cyc = 0;
   bit rdy_auto = 1'b0, rdy_force = 1'b0, finished = 1'b0;
   logic [CW-1:0] exp_q[$];

   always #4 clk = ~clk;

   charport_mmio uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .in_strobe(in_strobe), .in_byte(in_byte),
      .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
      .irq_in(irq_in), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata;
      chk("R10 ready", 32'(bus_ready), 32'h1);
      bus_sel = 1'b0;
   endtask

   task automatic strobe(input logic [CW-1:0] b);
      @(negedge clk);
      in_strobe = 1'b1; in_byte = b;
      @(negedge clk);
      in_strobe = 1'b0;
   endtask

   task automatic send_char(input logic [CW-1:0] b);
      logic [DW-1:0] st;
      bus_read(8'h11, st);
      while (st[0]) begin
         @(negedge clk);
         bus_read(8'h11, st);
      end
      bus_write(8'h10, 32'(b));
      bus_write(8'h11, 32'h1);
      exp_q.push_back(b);
   endtask

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rdy_auto) out_ready <= (cyc % 3) != 0;
      else          out_ready <= rdy_force;
   end

   initial forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
         hs_cnt++;
         if (exp_q.size() == 0) chk("R7 unexpected handshake", 32'(out_byte), 32'hFFFF_FFFF);
         else chk("R6 scoreboard byte", 32'(out_byte), 32'(exp_q.pop_front()));
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_read(8'h01, rd); chk("R1 rx status", rd, 0);
      bus_read(8'h11, rd); chk("R1 tx status", rd, 0);
      bus_read(8'h20, rd); chk("R1 ctrl", rd, 0);
      chk("R1 out_valid", 32'(out_valid), 0);
      chk("R1 irqs", {30'd0, irq_in, irq_out}, 0);

      // R10 unmapped, R11 control readback
      bus_read(8'h05, rd); chk("R10 unmapped", rd, 0);
      bus_write(8'h20, 32'h3);
      bus_read(8'h20, rd); chk("R11 ctrl", rd, 3);

      // R2 capture
      strobe(8'hA5);
      bus_read(8'h01, rd); chk("R2 full flag", rd, 1);
      bus_read(8'h00, rd); chk("R2 data", rd, 32'hA5);
      chk("R9 irq_in", 32'(irq_in), 1);

      // R3 overrun
      strobe(8'h3C);
      bus_read(8'h01, rd); chk("R3 overrun status", rd, 3);
      bus_read(8'h00, rd); chk("R3 data kept", rd, 32'hA5);

      // R4 write 1 keeps full, clears overrun; write 0 clears full
      bus_write(8'h01, 32'h1);
      bus_read(8'h01, rd); chk("R4 write1 keeps full", rd, 1);
      bus_write(8'h01, 32'h0);
      bus_read(8'h01, rd); chk("R4 ack clears", rd, 0);
      chk("R9 irq_in low", 32'(irq_in), 0);

      // R5 ack and strobe together
      strobe(8'h11);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h01; bus_wdata = 0;
      in_strobe = 1'b1; in_byte = 8'h22;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; in_strobe = 1'b0;
      bus_read(8'h01, rd); chk("R5 status", rd, 1);
      bus_read(8'h00, rd); chk("R5 data", rd, 32'h22);
      bus_write(8'h01, 32'h0);

      // R9 mask
      bus_write(8'h20, 32'h0);
      strobe(8'h44);
      chk("R9 irq_in masked", 32'(irq_in), 0);
      bus_write(8'h01, 32'h0);
      bus_write(8'h20, 32'h3);

      // R6 start with sink stalled
      bus_write(8'h10, 32'h5A);
      bus_write(8'h11, 32'h1);
      exp_q.push_back(8'h5A);
      bus_read(8'h11, rd); chk("R6 busy", rd, 1);
      chk("R6 out_valid", 32'(out_valid), 1);
      chk("R6 out_byte", 32'(out_byte), 32'h5A);

      // R8 writes while busy
      bus_write(8'h10, 32'h77);
      bus_write(8'h11, 32'h1);
      chk("R8 byte kept", 32'(out_byte), 32'h5A);
      bus_write(8'h11, 32'h0);
      bus_read(8'h11, rd); chk("R8 still busy", rd, 1);
      chk("R7 hold valid", 32'(out_valid), 1);

      // R7 completion
      rdy_force = 1'b1;
      repeat (3) @(negedge clk);
      rdy_force = 1'b0;
      @(negedge clk);
      bus_read(8'h11, rd); chk("R7 done status", rd, 2);
      chk("R7 valid low", 32'(out_valid), 0);
      chk("R9 irq_out", 32'(irq_out), 1);
      bus_write(8'h20, 32'h1);
      chk("R9 irq_out masked", 32'(irq_out), 0);

      // R9 done cleared by next start
      bus_write(8'h11, 32'h1);
      exp_q.push_back(8'h77);
      bus_read(8'h11, rd); chk("R9 start clears done", rd, 1);
      chk("R6 second byte", 32'(out_byte), 32'h77);

      // burst under changing ready
      rdy_auto = 1'b1;
      for (int i = 0; i < 6; i++) send_char(CW'(8'h30 + 7 * i));
      repeat (20) @(negedge clk);
      chk("R7 queue drained", 32'(exp_q.size()), 0);
      chk("R7 handshake count", 32'(hs_cnt), 8);
      finish_run();
   end
endmodule